// File: doc/BRIEF.md
# Auto-Baud and Wake-Up Line Monitor

This block watches the receive line of a serial port after its polarity has been corrected. It does two jobs. The first is to raise a wake interrupt on a falling edge while wake-up is armed. The second is to time a 55h synchronisation character and turn that timing into a divisor for a divide-by-4 or divide-by-16 baud counter.

The enable bits for both jobs live in a register outside the block. The block clears them by sending a one-cycle clear pulse when each job finishes. While a measurement is armed or running, a busy output keeps the transmit and receive engines idle.

The two jobs are linked. If auto-baud is armed when the wake falling edge arrives, that edge is taken as the start bit and timing begins on it. Timing runs from the first falling edge to the fifth one, which is eight bit times. If the counter overflows, the measurement is abandoned and the stored divisor is kept.

Top module: `abw_autobaud_wake`

## Requirements
- R1: After reset the divisor equals the DIV_RESET parameter, and busy, wake interrupt, overflow and both clear outputs are low.
- R2: With wake enable high, a falling edge on the synchronised line gives exactly one single-cycle wake interrupt pulse. With wake enable low, falling edges give no pulse.
- R3: After a wake falling edge, the wake-enable clear pulse comes only on the next rising edge of the line, as a single cycle. Wake enable stays high during the low period.
- R4: When auto-baud enable is high, busy goes high and the next falling edge starts the timing. This includes a falling edge that also raises the wake interrupt.
- R5: Let N be the number of clock cycles between the first and the fifth falling edge. The loaded divisor is floor(N / (8*F)) - 1, clamped at 0. F is 16 when high-speed select is 0 and 4 when it is 1.
- R6: When a measurement completes, the divisor loads, a single-cycle auto-baud-enable clear pulse is sent, and busy is low in that same cycle.
- R7: If the timing counter overflows (CNT_W bits) before the fifth falling edge, a single-cycle overflow pulse and an auto-baud-enable clear pulse are sent, and the divisor keeps its previous value.
- R8: If auto-baud enable is dropped before completion, the measurement is abandoned: busy falls, no clear pulse is sent, and the divisor is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Receive line after polarity handling, idle high |
| wake_en_i | input | 1 | Wake-up monitor enable (from the control register) |
| abd_en_i | input | 1 | Auto-baud measurement enable (from the control register) |
| high_speed_i | input | 1 | 1 selects divide-by-4, 0 selects divide-by-16 scaling |
| wake_irq_o | output | 1 | Single-cycle wake interrupt pulse |
| wake_en_clr_o | output | 1 | Single-cycle hardware clear of the wake enable |
| abd_en_clr_o | output | 1 | Single-cycle hardware clear of the auto-baud enable |
| abd_busy_o | output | 1 | High while auto-baud is armed or timing; holds off TX and RX |
| abd_ovf_o | output | 1 | Single-cycle auto-baud counter overflow pulse |
| baud_div_o | output | DIV_W | Measured baud divisor |

## Verification
The assertions check the following on every cycle:
- every interrupt, clear and overflow output is a single-cycle pulse;
- busy is never high in the cycle that clears the auto-baud enable;
- the divisor does not move when an overflow is reported;
- a wake-enable clear only follows a high line.

Only the bench scenarios can show the rest:
- the divisor arithmetic over a sweep of bit periods at both speed settings;
- the chaining of a wake edge into the start of timing;
- the exact rising edge that clears wake enable;
- the overflow and software-abort paths that leave the old divisor in place.

// File: rtl/abw_pkg.sv
package abw_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ARM  = 2'd1,
    MS_TIME = 2'd2,
    MS_HOLD = 2'd3
  } meas_state_t;

  typedef enum logic {
    WS_WAIT_FALL = 1'b0,
    WS_WAIT_RISE = 1'b1
  } wake_state_t;

  // Number of falling edges in a 55h sync character (start bit plus four).
  localparam int unsigned SYNC_FALLS = 5;
  // Bit times spanned from the first to the last of those edges.
  localparam int unsigned SYNC_BITS  = 8;

endpackage

// File: rtl/abw_rx_sync.sv
module abw_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= 1'b1;
    else     pipe_q[0] <= rx_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe_q[g] <= 1'b1;
      else     pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign fall_o  = pipe_q[STAGES] & ~pipe_q[STAGES-1];
  assign rise_o  = ~pipe_q[STAGES] & pipe_q[STAGES-1];

endmodule

// File: rtl/abw_wake_mon.sv
module abw_wake_mon
  import abw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wake_en_i,
  input  logic fall_i,
  input  logic rise_i,
  output logic irq_o,
  output logic clr_o
);

  wake_state_t state_q;
  logic        irq_q, clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_WAIT_FALL;
      irq_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      clr_q <= 1'b0;
      case (state_q)
        WS_WAIT_FALL: begin
          // clr_q guard: enable is still high for one cycle after the clear
          if (wake_en_i && !clr_q && fall_i) begin
            irq_q   <= 1'b1;
            state_q <= WS_WAIT_RISE;
          end
        end
        WS_WAIT_RISE: begin
          if (!wake_en_i) begin
            state_q <= WS_WAIT_FALL;
          end else if (rise_i) begin
            clr_q   <= 1'b1;
            state_q <= WS_WAIT_FALL;
          end
        end
        default: state_q <= WS_WAIT_FALL;
      endcase
    end
  end

  assign irq_o = irq_q;
  assign clr_o = clr_q;

  // R2: interrupt is a single-cycle pulse
  p_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R3: enable clear is a single-cycle pulse and never coincides with the interrupt
  p_clr_single_r3: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q);
  p_clr_not_irq_r3: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> !irq_q);

endmodule

// File: rtl/abw_baud_meas.sv
module abw_baud_meas
  import abw_pkg::*;
#(
  parameter int unsigned   CNT_W     = 20,
  parameter int unsigned   DIV_W     = 16,
  parameter logic [15:0]   DIV_RESET = 16'd0,
  parameter int unsigned   FACTOR_HS = 4,
  parameter int unsigned   FACTOR_LS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abd_en_i,
  input  logic             high_speed_i,
  input  logic             fall_i,
  output logic [DIV_W-1:0] div_o,
  output logic             busy_o,
  output logic             clr_o,
  output logic             ovf_o
);

  localparam int unsigned SHIFT_HS = $clog2(SYNC_BITS * FACTOR_HS);
  localparam int unsigned SHIFT_LS = $clog2(SYNC_BITS * FACTOR_LS);
  localparam int unsigned EDGE_W   = $clog2(SYNC_FALLS + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(SYNC_FALLS - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  meas_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edges_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q, clr_q, ovf_q;

  logic [CNT_W:0]    total;
  logic [CNT_W:0]    quot;
  logic [DIV_W-1:0]  div_calc;
  logic              finish, overflow;

  assign total    = {1'b0, cnt_q} + 1'b1;
  assign quot     = high_speed_i ? (total >> SHIFT_HS) : (total >> SHIFT_LS);
  assign div_calc = (quot == '0) ? '0 : DIV_W'(quot - 1'b1);

  assign finish   = (state_q == MS_TIME) && abd_en_i && fall_i && (edges_q == LAST_EDGE);
  assign overflow = (state_q == MS_TIME) && abd_en_i && !finish && (cnt_q == CNT_MAX);

  always_comb begin
    state_d = state_q;
    case (state_q)
      MS_IDLE: if (abd_en_i) state_d = MS_ARM;
      MS_ARM: begin
        if (!abd_en_i)   state_d = MS_IDLE;
        else if (fall_i) state_d = MS_TIME;
      end
      MS_TIME: begin
        if (!abd_en_i)               state_d = MS_IDLE;
        else if (finish || overflow) state_d = MS_HOLD;
      end
      MS_HOLD: if (!abd_en_i) state_d = MS_IDLE;
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      edges_q <= '0;
      div_q   <= DIV_W'(DIV_RESET);
      busy_q  <= 1'b0;
      clr_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d == MS_ARM) || (state_d == MS_TIME);
      clr_q   <= finish || overflow;
      ovf_q   <= overflow;
      if (state_q == MS_ARM && fall_i) begin
        cnt_q   <= '0;
        edges_q <= EDGE_W'(1);
      end else if (state_q == MS_TIME) begin
        cnt_q <= cnt_q + 1'b1;
        if (fall_i) edges_q <= edges_q + 1'b1;
      end
      if (finish) div_q <= div_calc;
    end
  end

  assign div_o  = div_q;
  assign busy_o = busy_q;
  assign clr_o  = clr_q;
  assign ovf_o  = ovf_q;

  // R6: completion clear is a single cycle and busy is already low with it
  p_clr_single_r6: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q);
  p_clr_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> !busy_q);

  // R7: an overflow leaves the divisor untouched and clears the enable
  p_ovf_keeps_div_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $stable(div_q));
  p_ovf_with_clr_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> clr_q);

  // R4: the divisor can only change at a clear pulse
  p_div_moves_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_q |-> $stable(div_q));

endmodule

// File: rtl/abw_autobaud_wake.sv
module abw_autobaud_wake #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned DIV_W       = 16,
  parameter logic [15:0] DIV_RESET   = 16'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             wake_en_i,
  input  logic             abd_en_i,
  input  logic             high_speed_i,
  output logic             wake_irq_o,
  output logic             wake_en_clr_o,
  output logic             abd_en_clr_o,
  output logic             abd_busy_o,
  output logic             abd_ovf_o,
  output logic [DIV_W-1:0] baud_div_o
);

  logic rx_level, rx_fall, rx_rise;

  abw_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rx_i    (rx_i),
    .level_o (rx_level),
    .fall_o  (rx_fall),
    .rise_o  (rx_rise)
  );

  abw_wake_mon u_wake (
    .clk       (clk),
    .rst       (rst),
    .wake_en_i (wake_en_i),
    .fall_i    (rx_fall),
    .rise_i    (rx_rise),
    .irq_o     (wake_irq_o),
    .clr_o     (wake_en_clr_o)
  );

  // The same falling-edge strobe feeds both units, so a wake edge seen
  // while auto-baud is armed is also the start of timing.
  abw_baud_meas #(
    .CNT_W     (CNT_W),
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) u_meas (
    .clk          (clk),
    .rst          (rst),
    .abd_en_i     (abd_en_i),
    .high_speed_i (high_speed_i),
    .fall_i       (rx_fall),
    .div_o        (baud_div_o),
    .busy_o       (abd_busy_o),
    .clr_o        (abd_en_clr_o),
    .ovf_o        (abd_ovf_o)
  );

  // R3: the wake-enable clear only follows a line that has gone high
  p_wake_clr_after_high_r3: assert property (@(posedge clk) disable iff (rst)
    wake_en_clr_o |-> $past(rx_level));

  // R7: overflow pulse is a single cycle
  p_ovf_single_r7: assert property (@(posedge clk) disable iff (rst)
    abd_ovf_o |=> !abd_ovf_o);

endmodule

// File: tb/abw_autobaud_wake_bench.sv
module abw_autobaud_wake_bench;

  localparam int unsigned CNT_W = 12;
  localparam int unsigned DIV_W = 8;
  localparam logic [15:0] DIV_RST = 16'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic hs = 1'b0;
  logic wake_en, abd_en;
  logic wake_set = 1'b0, abd_set = 1'b0, abd_kill = 1'b0;
  logic wake_irq, wake_clr, abd_clr, busy, ovf;
  logic [DIV_W-1:0] div;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0, wclr_cnt = 0, aclr_cnt = 0, ovf_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  abw_autobaud_wake #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RST)
  ) u_abw_autobaud_wake (
    .clk(clk), .rst(rst), .rx_i(rx),
    .wake_en_i(wake_en), .abd_en_i(abd_en), .high_speed_i(hs),
    .wake_irq_o(wake_irq), .wake_en_clr_o(wake_clr), .abd_en_clr_o(abd_clr),
    .abd_busy_o(busy), .abd_ovf_o(ovf), .baud_div_o(div)
  );

  // Software-side enable register model
  always @(posedge clk) begin
    if (rst) begin
      wake_en <= 1'b0;
      abd_en  <= 1'b0;
    end else begin
      if (wake_clr) wake_en <= 1'b0;
      else if (wake_set) wake_en <= 1'b1;
      if (abd_clr || abd_kill) abd_en <= 1'b0;
      else if (abd_set) abd_en <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (wake_irq) irq_cnt++;
      if (wake_clr) wclr_cnt++;
      if (abd_clr)  aclr_cnt++;
      if (ovf)      ovf_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_set(input int which);
    @(negedge clk);
    if (which == 0) wake_set = 1'b1; else if (which == 1) abd_set = 1'b1; else abd_kill = 1'b1;
    @(negedge clk);
    wake_set = 1'b0; abd_set = 1'b0; abd_kill = 1'b0;
  endtask

  task automatic drive_bit(input logic v, input int t);
    rx = v;
    repeat (t) @(negedge clk);
  endtask

  task automatic send_sync(input int t);
    drive_bit(1'b0, t);
    for (int b = 0; b < 8; b++) drive_bit(b[0] ? 1'b0 : 1'b1, t);
    drive_bit(1'b1, t);
    repeat (2 * t + 6) @(negedge clk);
  endtask

  function automatic int expect_div(input int t, input bit h);
    int q;
    q = (8 * t) / (8 * (h ? 4 : 16));
    return (q == 0) ? 0 : q - 1;
  endfunction

  task automatic measure(input int t, input bit h, input bit with_wake);
    int a0, i0, w0;
    @(negedge clk);
    hs = h;
    a0 = aclr_cnt; i0 = irq_cnt; w0 = wclr_cnt;
    if (with_wake) pulse_set(0);
    pulse_set(1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R4 busy when armed", busy, 1);
    send_sync(t);
    chk(div == DIV_W'(expect_div(t, h)), "R5 divisor", div, expect_div(t, h));
    chk(aclr_cnt == a0 + 1, "R6 one enable clear", aclr_cnt - a0, 1);
    chk(busy == 1'b0 && abd_en == 1'b0, "R6 busy and enable low", busy, 0);
    if (with_wake) begin
      chk(irq_cnt == i0 + 1, "R4 chained wake irq count", irq_cnt - i0, 1);
      chk(wclr_cnt == w0 + 1, "R3 chained wake clear", wclr_cnt - w0, 1);
    end else begin
      chk(irq_cnt == i0, "R2 no irq without wake enable", irq_cnt - i0, 0);
    end
  endtask

  initial begin : main
    int i0, w0, a0, o0;
    logic [DIV_W-1:0] kept;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(div == DIV_W'(DIV_RST), "R1 divisor reset", div, DIV_RST);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(wake_irq == 1'b0 && wake_clr == 1'b0, "R1 wake outputs reset", wake_irq, 0);
    chk(abd_clr == 1'b0 && ovf == 1'b0, "R1 auto-baud pulses reset", ovf, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 no wake pulse while disabled
    i0 = irq_cnt;
    drive_bit(1'b0, 10); drive_bit(1'b1, 10);
    chk(irq_cnt == i0, "R2 disabled wake ignored", irq_cnt - i0, 0);

    // R2/R3 wake-up alone
    pulse_set(0);
    i0 = irq_cnt; w0 = wclr_cnt;
    drive_bit(1'b0, 20);
    chk(irq_cnt == i0 + 1, "R2 one wake pulse", irq_cnt - i0, 1);
    chk(wake_en == 1'b1 && wclr_cnt == w0, "R3 enable held while low", wclr_cnt - w0, 0);
    drive_bit(1'b1, 10);
    chk(wclr_cnt == w0 + 1, "R3 clear on rising edge", wclr_cnt - w0, 1);
    chk(wake_en == 1'b0, "R3 wake enable cleared", wake_en, 0);
    drive_bit(1'b0, 10); drive_bit(1'b1, 10);
    chk(irq_cnt == i0 + 1, "R2 no pulse after clear", irq_cnt - i0, 1);

    // R5 sweeps at both speeds
    for (int t = 16; t <= 64; t += 4) measure(t, 1'b0, 1'b0);
    for (int t = 4; t <= 32; t += 2) measure(t, 1'b1, 1'b0);
    measure(37, 1'b0, 1'b0);
    // R4 chained wake and measurement
    measure(24, 1'b0, 1'b1);
    measure(9, 1'b1, 1'b1);

    // R7 overflow keeps divisor
    kept = div; a0 = aclr_cnt; o0 = ovf_cnt;
    hs = 1'b0;
    pulse_set(1);
    repeat (3) @(negedge clk);
    send_sync(600);
    chk(ovf_cnt == o0 + 1, "R7 one overflow pulse", ovf_cnt - o0, 1);
    chk(aclr_cnt == a0 + 1, "R7 enable cleared", aclr_cnt - a0, 1);
    chk(div == kept, "R7 divisor kept", div, kept);
    chk(busy == 1'b0, "R7 busy low", busy, 0);

    // R8 software abort
    kept = div; a0 = aclr_cnt;
    pulse_set(1);
    repeat (3) @(negedge clk);
    drive_bit(1'b0, 20);
    drive_bit(1'b1, 20);
    pulse_set(2);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8 busy dropped", busy, 0);
    chk(aclr_cnt == a0, "R8 no clear pulse", aclr_cnt - a0, 0);
    chk(div == kept, "R8 divisor unchanged", div, kept);

    // R5 after abort, a fresh measurement still works
    measure(48, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule